// File: doc/BRIEF.md
# Two-Wire Serial Slave Register Bank

This block is a receive-only slave on a two-wire serial bus (clock line and data line, both open-drain with pull-ups). It holds a bank of eight-bit control registers. A bus master can write any one of them with a three-byte transfer: device address, register index, value. The block oversamples both bus lines with a fast system clock. It removes short spikes, frames bits and bytes, recognises its own write address, and acknowledges each accepted byte by pulling the data line low. The whole bank is presented in parallel on one flat output vector, so the surrounding logic reads its settings directly.

The data line is never driven high. The block only asserts an enable that tells the pad to pull the line low. A bus clock of up to 400 kHz is supported as long as the system clock is fast enough for the spike filter and the edge detection, which add a few cycles of delay (see the trade-offs note).

Top module: `twi_regfile`

## Requirements
- R1: A change on either bus line is accepted only after the synchronised input has held the new level for FILT_CYCLES consecutive system-clock cycles. A shorter pulse on the clock line or the data line has no effect on framing or on register contents.
- R2: A transfer begins only with a START (data line falls while the clock line is high). A STOP (data line rises while the clock line is high) returns the block to idle. Bytes clocked without a preceding START get no acknowledge and write nothing.
- R3: Each byte is eight bits taken on rising clock-line edges, most significant bit first. To acknowledge, `sdaOe` is set while the clock line is low after the eighth bit and stays set until the clock line falls at the end of the ninth pulse. `sdaOe` changes only while the clock line is low.
- R4: Only the address byte 0x8C (7-bit address 0x46 with the direction bit 0) is acknowledged. Any other address byte, including 0x8D and 0x0C, gets no acknowledge, and the rest of that transfer is ignored until the next START.
- R5: The register-index byte is always acknowledged after a matching address. Only its low 5 bits select a register; the upper 3 bits are ignored.
- R6: The value byte is acknowledged and written into the selected register. Register i appears on `regsOut[8*i+7:8*i]`. Register contents change only through such a write or a reset.
- R7: An index of 24 or more, after masking to 5 bits, is acknowledged together with its value byte, but no register changes.
- R8: A START received in the middle of a transfer discards the partial transfer and restarts address reception.
- R9: After the value byte is acknowledged, further bytes in the same transfer are not acknowledged and write nothing.
- R10: A synchronous reset sets every register to RESET_VAL, clears `sdaOe` and returns the protocol to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sdaOe | output | 1 | 1 = pull the data line low, 0 = release it |
| regsOut | output | NUM_REGS*8 | All registers concatenated, register 0 in the low byte |

## Verification
The bench builds the block with 24 registers, a 5-cycle spike filter, device address 0x46 and a reset value of 0xA5. The non-zero reset value lets a lost or stray write show up on the output vector. The 5-cycle filter lets 3-cycle spikes on the clock line (a false bit) and on the data line (a false START or STOP) be injected within a single bit. The 24-entry bank leaves indices 24 to 31 reachable through the 5-bit index, so both the last valid register and the discarded range are exercised.

// File: rtl/twi_regfile_pkg.sv
package twi_regfile_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } twiState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftBit;
    logic clrBits;
    logic latchSub;
    logic writeReg;
  } dpStrobe_t;

endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
  parameter int unsigned CYCLES      = 5,
  parameter logic        RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic cleanOut
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ    <= {2{RESET_LEVEL}};
      cleanOut <= RESET_LEVEL;
      holdCnt  <= '0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == cleanOut) begin
        holdCnt <= '0;
      end else if (holdCnt == CNT_W'(CYCLES - 1)) begin
        cleanOut <= syncQ[1];
        holdCnt  <= '0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/twi_regfile_ctrl.sv
module twi_regfile_ctrl
  import twi_regfile_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sclF,
  input  logic      sdaF,
  input  logic      byteDone,
  input  logic      addrHit,
  output dpStrobe_t dpCtl,
  output logic      sdaOe,
  output logic      stopSeen
);

  twiState_e state, stateNext;
  logic sclPrev, sdaPrev;
  logic sclRise, sclFall, startCond, stopCond;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  assign sclRise   = sclF & ~sclPrev;
  assign sclFall   = ~sclF & sclPrev;
  assign startCond = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopCond  = sclF & sclPrev & ~sdaPrev & sdaF;
  assign stopSeen  = stopCond;

  always_comb begin
    stateNext = state;
    dpCtl     = '0;
    if (startCond) begin
      stateNext     = ST_ADDR;
      dpCtl.clrBits = 1'b1;
    end else if (stopCond) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: begin
          dpCtl.shiftBit = sclRise;
          if (sclFall && byteDone) stateNext = addrHit ? ST_ADDR_ACK : ST_SKIP;
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            stateNext     = ST_SUB;
            dpCtl.clrBits = 1'b1;
          end
        end
        ST_SUB: begin
          dpCtl.shiftBit = sclRise;
          if (sclFall && byteDone) begin
            stateNext      = ST_SUB_ACK;
            dpCtl.latchSub = 1'b1;
          end
        end
        ST_SUB_ACK: begin
          if (sclFall) begin
            stateNext     = ST_DATA;
            dpCtl.clrBits = 1'b1;
          end
        end
        ST_DATA: begin
          dpCtl.shiftBit = sclRise;
          if (sclFall && byteDone) begin
            stateNext      = ST_DATA_ACK;
            dpCtl.writeReg = 1'b1;
          end
        end
        ST_DATA_ACK: begin
          if (sclFall) stateNext = ST_SKIP;
        end
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      sdaOe <= 1'b0;
    end else begin
      state <= stateNext;
      sdaOe <= (stateNext == ST_ADDR_ACK) || (stateNext == ST_SUB_ACK) ||
               (stateNext == ST_DATA_ACK);
    end
  end

endmodule

// File: rtl/twi_regfile_dp.sv
module twi_regfile_dp
  import twi_regfile_pkg::*;
#(
  parameter int unsigned  NUM_REGS  = 24,
  parameter logic [6:0]   DEV_ADDR  = 7'h46,
  parameter logic [7:0]   RESET_VAL = 8'h00
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sdaF,
  input  dpStrobe_t                  dpCtl,
  output logic                       byteDone,
  output logic                       addrHit,
  output logic [NUM_REGS*BYTE_W-1:0] regsOut
);

  localparam int SUB_BITS = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [BYTE_W-1:0]   shiftQ;
  logic [3:0]          bitCnt;
  logic [SUB_BITS-1:0] subIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ <= '0;
      bitCnt <= '0;
      subIdx <= '0;
    end else begin
      if (dpCtl.clrBits) begin
        bitCnt <= '0;
      end else if (dpCtl.shiftBit) begin
        shiftQ <= {shiftQ[BYTE_W-2:0], sdaF};
        bitCnt <= bitCnt + 1'b1;
      end
      if (dpCtl.latchSub) subIdx <= shiftQ[SUB_BITS-1:0];
    end
  end

  assign byteDone = (bitCnt == 4'(BYTE_W));
  assign addrHit  = (shiftQ == {DEV_ADDR, 1'b0});

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [BYTE_W-1:0] regQ;
    always_ff @(posedge clk) begin
      if (rst)                                           regQ <= RESET_VAL;
      else if (dpCtl.writeReg && subIdx == SUB_BITS'(i)) regQ <= shiftQ;
    end
    assign regsOut[i*BYTE_W +: BYTE_W] = regQ;
  end

endmodule

// File: rtl/twi_regfile.sv
module twi_regfile
  import twi_regfile_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 24,
  parameter int unsigned FILT_CYCLES = 5,
  parameter logic [6:0]  DEV_ADDR    = 7'h46,
  parameter logic [7:0]  RESET_VAL   = 8'h00
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaOe,
  output logic [NUM_REGS*BYTE_W-1:0] regsOut
);

  logic      sclClean, sdaClean;
  logic      byteDone, addrHit, stopSeen;
  dpStrobe_t dpCtl;

  twi_glitch_filter #(.CYCLES(FILT_CYCLES), .RESET_LEVEL(1'b1)) u_sclFilt (
    .clk(clk), .rst(rst), .rawIn(sclIn), .cleanOut(sclClean)
  );

  twi_glitch_filter #(.CYCLES(FILT_CYCLES), .RESET_LEVEL(1'b1)) u_sdaFilt (
    .clk(clk), .rst(rst), .rawIn(sdaIn), .cleanOut(sdaClean)
  );

  twi_regfile_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sclF(sclClean), .sdaF(sdaClean),
    .byteDone(byteDone), .addrHit(addrHit), .dpCtl(dpCtl),
    .sdaOe(sdaOe), .stopSeen(stopSeen)
  );

  twi_regfile_dp #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .RESET_VAL(RESET_VAL)) u_dp (
    .clk(clk), .rst(rst), .sdaF(sdaClean), .dpCtl(dpCtl),
    .byteDone(byteDone), .addrHit(addrHit), .regsOut(regsOut)
  );

endmodule

// File: rtl/twi_regfile_chk.sv
module twi_regfile_chk #(
  parameter int unsigned REG_BITS = 192
) (
  input logic                clk,
  input logic                rst,
  input logic                sclF,
  input logic                sdaOe,
  input logic                wrStrobe,
  input logic                stopSeen,
  input logic [REG_BITS-1:0] regsOut
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R3: acknowledge drive is raised only while the clock line is low
  a_r3_ack_set_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sdaOe) |-> !sclF);

  // R3: acknowledge drive is released only while the clock line is low
  a_r3_ack_release_low: assert property (@(posedge clk) disable iff (rst)
    $fell(sdaOe) |-> !sclF);

  // R3: no change of the drive while the clock line stays high
  a_r3_steady_high: assert property (@(posedge clk) disable iff (rst)
    (sclF && $past(sclF)) |-> $stable(sdaOe));

  // R6: register bank only changes right after a write strobe
  a_r6_change_on_write: assert property (@(posedge clk) disable iff (rst)
    (armed && !$stable(regsOut)) |-> $past(wrStrobe));

  // R2: after a STOP the line is released
  a_r2_stop_released: assert property (@(posedge clk) disable iff (rst)
    stopSeen |=> !sdaOe);

endmodule

bind twi_regfile twi_regfile_chk #(.REG_BITS(NUM_REGS * 8)) u_chk (
  .clk(clk), .rst(rst), .sclF(sclClean), .sdaOe(sdaOe),
  .wrStrobe(dpCtl.writeReg), .stopSeen(stopSeen), .regsOut(regsOut)
);

// File: tb/twi_regfile_bench.sv
module twi_regfile_bench;

  localparam int         NREG  = 24;
  localparam int         FILT  = 5;
  localparam logic [7:0] RVAL  = 8'hA5;
  localparam int         Q     = 40;
  localparam int         NVEC  = 9;

  // {address byte, index byte, value byte, expected acks {addr, index, value}}
  localparam logic [26:0] VEC [NVEC] = '{
    {8'h8C, 8'h03, 8'h5A, 3'b111},
    {8'h8C, 8'h17, 8'hC3, 3'b111},
    {8'h8C, 8'hE5, 8'h3C, 3'b111},
    {8'h8C, 8'h18, 8'h99, 3'b111},
    {8'h8C, 8'h1F, 8'h77, 3'b111},
    {8'h8D, 8'h02, 8'h11, 3'b000},
    {8'h8E, 8'h04, 8'h22, 3'b000},
    {8'h8C, 8'h00, 8'hFF, 3'b111},
    {8'h0C, 8'h01, 8'h12, 3'b000}
  };

  logic clk = 1'b0;
  logic rst;
  logic sclDrv, sdaDrv;
  logic sdaOe;
  logic sdaLine;
  logic [NREG*8-1:0] regsOut;
  logic [7:0] model [NREG];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign sdaLine = sdaDrv & ~sdaOe;

  twi_regfile #(.NUM_REGS(NREG), .FILT_CYCLES(FILT), .DEV_ADDR(7'h46), .RESET_VAL(RVAL))
    u_twi_regfile (
      .clk(clk), .rst(rst), .sclIn(sclDrv), .sdaIn(sdaLine),
      .sdaOe(sdaOe), .regsOut(regsOut)
    );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic checkRegs(input string req);
    logic [NREG*8-1:0] exp;
    for (int i = 0; i < NREG; i++) exp[i*8 +: 8] = model[i];
    nChecks++;
    if (regsOut !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, regsOut, exp);
    end
  endtask

  task automatic sendStart();
    sdaDrv = 1'b1; idle(Q);
    sclDrv = 1'b1; idle(Q);
    sdaDrv = 1'b0; idle(Q);
    sclDrv = 1'b0; idle(Q);
  endtask

  task automatic sendStop();
    sdaDrv = 1'b0; idle(Q);
    sclDrv = 1'b1; idle(Q);
    sdaDrv = 1'b1; idle(Q);
  endtask

  task automatic sendBit(input logic b, input bit sclSpike, input bit sdaSpike);
    sdaDrv = b;
    if (sclSpike) begin
      idle(Q/2); sclDrv = 1'b1; idle(FILT-2); sclDrv = 1'b0; idle(Q/2 - (FILT-2));
    end else begin
      idle(Q);
    end
    sclDrv = 1'b1;
    if (sdaSpike) begin
      idle(Q); sdaDrv = ~b; idle(FILT-2); sdaDrv = b; idle(Q - (FILT-2));
    end else begin
      idle(2*Q);
    end
    sclDrv = 1'b0; idle(Q);
  endtask

  task automatic readAck(output logic ack);
    sdaDrv = 1'b1; idle(Q);
    sclDrv = 1'b1; idle(Q);
    ack = ~sdaLine;
    idle(Q);
    sclDrv = 1'b0; idle(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit spike, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i], spike && i == 4, spike && i == 2);
    readAck(ack);
  endtask

  task automatic modelWrite(input logic [7:0] idx, input logic [7:0] v);
    if (idx[4:0] < 5'(NREG)) model[idx[4:0]] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2;
    rst = 1'b1; sclDrv = 1'b1; sdaDrv = 1'b1;
    for (int i = 0; i < NREG; i++) model[i] = RVAL;
    idle(10);
    rst = 1'b0;
    idle(4);
    // R10: reset state
    checkRegs("R10 reset values");
    checkBit("R10 sdaOe after reset", sdaOe, 1'b0);

    // table: R4 R5 R6 R7 (address match, index masking, write, out-of-range index)
    for (int v = 0; v < NVEC; v++) begin
      sendStart();
      sendByte(VEC[v][26:19], 1'b0, a0);
      sendByte(VEC[v][18:11], 1'b0, a1);
      sendByte(VEC[v][10:3],  1'b0, a2);
      sendStop();
      idle(Q);
      if (VEC[v][2]) modelWrite(VEC[v][18:11], VEC[v][10:3]);
      checkBit($sformatf("R4 addr ack vec %0d", v), a0, VEC[v][2]);
      checkBit($sformatf("R5 index ack vec %0d", v), a1, VEC[v][1]);
      checkBit($sformatf("R7 value ack vec %0d", v), a2, VEC[v][0]);
      checkRegs($sformatf("R6 bank after vec %0d", v));
      checkBit($sformatf("R3 released after vec %0d", v), sdaOe, 1'b0);
    end

    // R2: byte without START is ignored
    sendByte(8'h8C, 1'b0, a0);
    sendByte(8'h06, 1'b0, a1);
    sendByte(8'h31, 1'b0, a2);
    sendStop();
    idle(Q);
    checkBit("R2 no ack without START", a0 | a1 | a2, 1'b0);
    checkRegs("R2 bank unchanged without START");

    // R8: repeated START mid-transfer restarts address phase
    sendStart();
    sendByte(8'h8C, 1'b0, a0);
    sendByte(8'h04, 1'b0, a1);
    sendStart();
    sendByte(8'h8C, 1'b0, a0);
    sendByte(8'h06, 1'b0, a1);
    sendByte(8'h6B, 1'b0, a2);
    sendStop();
    idle(Q);
    modelWrite(8'h06, 8'h6B);
    checkBit("R8 acks after repeated START", a0 & a1 & a2, 1'b1);
    checkRegs("R8 only restarted transfer written");

    // R9: extra byte after value is not acked and not written
    sendStart();
    sendByte(8'h8C, 1'b0, a0);
    sendByte(8'h09, 1'b0, a1);
    sendByte(8'h44, 1'b0, a2);
    sendByte(8'h55, 1'b0, a0);
    sendStop();
    idle(Q);
    modelWrite(8'h09, 8'h44);
    checkBit("R9 extra byte not acked", a0, 1'b0);
    checkRegs("R9 extra byte not written");

    // R1: short spikes on both lines inside every byte
    sendStart();
    sendByte(8'h8C, 1'b1, a0);
    sendByte(8'h0A, 1'b1, a1);
    sendByte(8'hA3, 1'b1, a2);
    sendStop();
    idle(Q);
    modelWrite(8'h0A, 8'hA3);
    checkBit("R1 acks despite spikes", a0 & a1 & a2, 1'b1);
    checkRegs("R1 spikes rejected");

    // R10: reset after writes
    @(negedge clk); rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(2);
    for (int i = 0; i < NREG; i++) model[i] = RVAL;
    checkRegs("R10 reset after writes");
    checkBit("R10 sdaOe after late reset", sdaOe, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule